// File: doc/BRIEF.md
# Reload-and-Match Timer PWM Generator

This block produces one pulse-width-modulated output from a 32-bit up-counter. The counter advances on a tick that comes either from every clock or from a power-of-two prescaler. When the counter steps past the all-ones value it reloads from a programmable reload register. A programmable compare point marks where the active phase ends. The output toggles on the wrap and again on the compare event, so the reload value sets the period and the compare point sets the duty.

Software sets up the block through a simple one-cycle register port. While the timer is stopped it writes the reload, compare, prescaler and polarity settings. It then primes the counter at 0xFFFFFFFE, so that the first event after start is a wrap, and finally sets the run bit. Configuration writes made while the timer runs are dropped and raise a sticky error flag. To reconfigure, software stops the timer, writes the new values, primes the counter again and restarts it. The port carries no streaming data, so every pin is a plain control or status signal with no back-pressure.

Top module: `reload_match_pwm`

## Requirements
- R1: After reset, pwm_out is 0 and every register reads 0, including the error flag.
- R2: While running, the counter rises by one on each tick. On a tick with the counter at 0xFFFFFFFF it loads the reload value instead (wrap event), and the output toggles.
- R3: A tick with the counter equal to the compare value toggles the output. For reload L and compare M, the active phase lasts M-L+1 ticks and the inactive phase lasts 0xFFFFFFFF-M ticks.
- R4: Starting clears the toggle state. With the counter primed at 0xFFFFFFFE and M below 0xFFFFFFFE, the output first turns active 2 ticks after the start write.
- R5: The prescaler register holds the divider field in bits 2:0 and the enable in bit 3. When enabled, one tick occurs every 2^(field+1) clocks. When disabled, a tick occurs on every clock.
- R6: Control bit 1 inverts the output level. It takes effect only when written while the timer is stopped, and a write made while running leaves it unchanged.
- R7: While stopped, pwm_out holds the idle level (0, or 1 when inverted) and the counter holds its value.
- R8: A write to the reload, compare, counter or prescaler register while running is ignored and sets the sticky error flag (control read bit 2). A control write with bit 2 set clears the flag.
- R9: Register selects: 0 control (bit 0 run, bit 1 invert, bit 2 error clear on write and error status on read), 1 reload, 2 compare, 3 counter, 4 prescaler. Reads are combinational. Selects 5 to 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 32 | Combinational read data |
| pwm_out | output | 1 | PWM output |

## Verification
A counter that steps or reloads wrongly shows at pwm_out within one period, because the measured active and inactive lengths drift from M-L+1 and 0xFFFFFFFF-M ticks. It also shows at once on a counter read-back after a stop. A lost toggle or a wrong prescaler cadence shifts the first active edge away from 2 ticks after start, and this is visible within a few clocks. A write-protection fault shows on the next read of the register it altered or of the error bit.

// File: rtl/reload_match_pwm_pkg.sv
package reload_match_pwm_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_LOAD  = 3'd1,
    SEL_MATCH = 3'd2,
    SEL_COUNT = 3'd3,
    SEL_PSC   = 3'd4
  } reg_sel_e;

  localparam int CTRL_RUN = 0;
  localparam int CTRL_INV = 1;
  localparam int CTRL_ERR = 2;
endpackage

// File: rtl/rmp_regfile.sv
module rmp_regfile
  import reload_match_pwm_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rd_data,
  output logic             run_q,
  output logic             inv_q,
  output logic             err_q,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] match_q,
  output logic             psc_en_q,
  output logic [PSC_W-1:0] psc_field_q,
  output logic             cnt_wr,
  output logic             stop_req
);
  logic ctrl_wr, cfg_wr, blocked;

  always_comb begin
    ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
    cfg_wr   = wr_en && ((wr_sel == SEL_LOAD) || (wr_sel == SEL_MATCH) ||
                         (wr_sel == SEL_COUNT) || (wr_sel == SEL_PSC));
    blocked  = cfg_wr && run_q;
    cnt_wr   = wr_en && (wr_sel == SEL_COUNT) && !run_q;
    stop_req = ctrl_wr && !wr_data[CTRL_RUN] && run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      inv_q       <= 1'b0;
      load_q      <= '0;
      match_q     <= '0;
      psc_en_q    <= 1'b0;
      psc_field_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CTRL: begin
          run_q <= wr_data[CTRL_RUN];
          if (!run_q) inv_q <= wr_data[CTRL_INV];
        end
        SEL_LOAD:  if (!run_q) load_q  <= wr_data;
        SEL_MATCH: if (!run_q) match_q <= wr_data;
        SEL_PSC: if (!run_q) begin
          psc_en_q    <= wr_data[PSC_W];
          psc_field_q <= wr_data[PSC_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // sticky protection error: set by a dropped write, cleared by control bit 2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               err_q <= 1'b0;
    else if (blocked)                         err_q <= 1'b1;
    else if (ctrl_wr && wr_data[CTRL_ERR])    err_q <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CTRL: begin
        rd_data[CTRL_RUN] = run_q;
        rd_data[CTRL_INV] = inv_q;
        rd_data[CTRL_ERR] = err_q;
      end
      SEL_LOAD:  rd_data = load_q;
      SEL_MATCH: rd_data = match_q;
      SEL_COUNT: rd_data = cnt_q;
      SEL_PSC:   rd_data = CNT_W'({psc_en_q, psc_field_q});
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rmp_prescaler.sv
module rmp_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic [PSC_W-1:0] field,
  output logic             tick
);
  localparam int PC_W = 1 << PSC_W;
  localparam logic [PSC_W-1:0] FMAX = PSC_W'(PC_W - 1);

  logic [PC_W-1:0]  pc_q;
  logic [PC_W-1:0]  limit;
  logic [PSC_W-1:0] shamt;

  // limit = 2^(field+1) - 1, built as a right-shifted all-ones mask
  always_comb begin
    shamt = FMAX - field;
    limit = {PC_W{1'b1}} >> shamt;
    tick  = run && (!en || (pc_q == limit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pc_q <= '0;
    else if (!run || !en)            pc_q <= '0;
    else if (pc_q == limit)          pc_q <= '0;
    else                             pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/rmp_counter.sv
module rmp_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_q,
  input  logic [CNT_W-1:0] match_q,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wr_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt,
  output logic             match_evt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_comb begin
    ovf_evt   = tick && (cnt_q == TOP);
    match_evt = tick && (cnt_q == match_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_wr)   cnt_q <= cnt_wr_val;
    else if (ovf_evt)  cnt_q <= load_q;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rmp_wave.sv
module rmp_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic run_q,
  input  logic stop_req,
  input  logic inv_q,
  input  logic ovf_evt,
  input  logic match_evt,
  output logic pwm_out
);
  logic tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tgl_q <= 1'b0;
    else if (!run_q || stop_req)   tgl_q <= 1'b0;
    else if (ovf_evt || match_evt) tgl_q <= ~tgl_q;
  end

  assign pwm_out = tgl_q ^ inv_q;
endmodule

// File: rtl/reload_match_pwm.sv
module reload_match_pwm
  import reload_match_pwm_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             pwm_out
);
  logic             run_q, inv_q, err_q, psc_en_q, cnt_wr, stop_req;
  logic             tick, ovf_evt, match_evt;
  logic [CNT_W-1:0] load_q, match_q, cnt_q;
  logic [PSC_W-1:0] psc_field_q;

  rmp_regfile #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .cnt_q(cnt_q), .rd_data(rd_data),
    .run_q(run_q), .inv_q(inv_q), .err_q(err_q), .load_q(load_q),
    .match_q(match_q), .psc_en_q(psc_en_q), .psc_field_q(psc_field_q),
    .cnt_wr(cnt_wr), .stop_req(stop_req)
  );

  rmp_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .en(psc_en_q),
    .field(psc_field_q), .tick(tick)
  );

  rmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_q(load_q),
    .match_q(match_q), .cnt_wr(cnt_wr), .cnt_wr_val(wr_data),
    .cnt_q(cnt_q), .ovf_evt(ovf_evt), .match_evt(match_evt)
  );

  rmp_wave u_wave (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .stop_req(stop_req),
    .inv_q(inv_q), .ovf_evt(ovf_evt), .match_evt(match_evt),
    .pwm_out(pwm_out)
  );
endmodule

// File: rtl/rmp_chk.sv
module rmp_chk
  import reload_match_pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic             wr_run_bit,
  input logic             wr_inv_bit,
  input logic             pwm_out,
  input logic             run_q,
  input logic             inv_q,
  input logic             err_q,
  input logic [CNT_W-1:0] load_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             tick,
  input logic             psc_en,
  input logic             ovf_evt,
  input logic             match_evt
);
  logic ctrl_wr, start_req, stop_w, evt;
  assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
  assign start_req = ctrl_wr && wr_run_bit && !run_q;
  assign stop_w    = ctrl_wr && !wr_run_bit && run_q;
  assign evt       = ovf_evt || match_evt;

  a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (pwm_out == inv_q));

  a_r8_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel == SEL_LOAD) && run_q) |=> ($stable(load_q) && err_q));

  a_r2_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == $past(load_q)));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ovf_evt) |=> (cnt_q == $past(cnt_q) + {{(CNT_W-1){1'b0}}, 1'b1}));

  a_r3_toggle_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !stop_w) |=> (pwm_out != $past(pwm_out)));

  a_r6_hold_between_events: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !evt && !ctrl_wr) |=> $stable(pwm_out));

  a_r4_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (pwm_out == $past(wr_inv_bit)));

  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && psc_en && tick) |=> !tick);
endmodule

bind reload_match_pwm rmp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_run_bit(wr_data[0]), .wr_inv_bit(wr_data[1]), .pwm_out(pwm_out),
  .run_q(run_q), .inv_q(inv_q), .err_q(err_q), .load_q(load_q),
  .cnt_q(cnt_q), .tick(tick), .psc_en(psc_en_q), .ovf_evt(ovf_evt),
  .match_evt(match_evt)
);

// File: tb/sim_reload_match_pwm.sv
`timescale 1ns/1ps
module sim_reload_match_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reload_match_pwm u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic [31:0] load;
    logic [31:0] match;
    logic        psc_en;
    logic [2:0]  psc_f;
    logic        inv;
    logic [15:0] first;
    logic [15:0] act;
    logic [15:0] inact;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{32'hFFFF_FFF0, 32'hFFFF_FFF3, 1'b0, 3'd0, 1'b0, 16'd2,   16'd4,   16'd12},
    '{32'hFFFF_FFFD, 32'hFFFF_FFFD, 1'b0, 3'd0, 1'b0, 16'd2,   16'd1,   16'd2},
    '{32'hFFFF_FFF0, 32'hFFFF_FFFD, 1'b0, 3'd0, 1'b1, 16'd2,   16'd14,  16'd2},
    '{32'hFFFF_FFFA, 32'hFFFF_FFFB, 1'b1, 3'd1, 1'b0, 16'd8,   16'd8,   16'd16},
    '{32'hFFFF_FFF8, 32'hFFFF_FFF8, 1'b1, 3'd0, 1'b1, 16'd4,   16'd2,   16'd14},
    '{32'hFFFF_FFFD, 32'hFFFF_FFFD, 1'b1, 3'd7, 1'b0, 16'd512, 16'd256, 16'd512}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  initial begin
    #(64'd4000000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pwm_out", {31'd0, pwm_out}, 32'd0);
    rd(3'd0, v); chk("R1 ctrl", v, 32'd0);
    rd(3'd1, v); chk("R1 reload", v, 32'd0);
    rd(3'd3, v); chk("R1 counter", v, 32'd0);
    rd(3'd4, v); chk("R1 prescaler", v, 32'd0);

    // vector table: R3 phases, R4 first edge, R5 prescaler, R6 polarity
    for (int i = 0; i < NV; i++) begin
      int k, h, l;
      logic a;
      wr(3'd0, 32'd0);
      wr(3'd1, VEC[i].load);
      wr(3'd2, VEC[i].match);
      wr(3'd4, {28'd0, VEC[i].psc_en, VEC[i].psc_f});
      wr(3'd3, 32'hFFFF_FFFE);
      wr(3'd0, {30'd0, VEC[i].inv, 1'b0});
      @(negedge clk);
      chk($sformatf("R6 R7 idle level vec%0d", i), {31'd0, pwm_out}, {31'd0, VEC[i].inv});
      wr(3'd0, {30'd0, VEC[i].inv, 1'b1});
      k = 0;
      @(negedge clk); a = pwm_out ^ VEC[i].inv;
      while (!a && k < 4000) begin k++; @(negedge clk); a = pwm_out ^ VEC[i].inv; end
      chk($sformatf("R4 R5 first active vec%0d", i), k, {16'd0, VEC[i].first});
      h = 0;
      while (a && h < 4000) begin h++; @(negedge clk); a = pwm_out ^ VEC[i].inv; end
      l = 0;
      while (!a && l < 4000) begin l++; @(negedge clk); a = pwm_out ^ VEC[i].inv; end
      chk($sformatf("R3 R5 active length vec%0d", i), h, {16'd0, VEC[i].act});
      chk($sformatf("R3 R2 inactive length vec%0d", i), l, {16'd0, VEC[i].inact});
    end

    // R2 stepping: 10 ticks from 5
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd100);
    wr(3'd3, 32'd5);
    wr(3'd0, 32'd1);
    repeat (9) @(negedge clk);
    wr(3'd0, 32'd0);
    rd(3'd3, v); chk("R2 count step", v, 32'd15);

    // R2 wrap reload, R7 idle after stop
    wr(3'd1, 32'h100);
    wr(3'd2, 32'h200);
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd0, 32'd1);
    wr(3'd0, 32'd0);
    rd(3'd3, v); chk("R2 wrap reload", v, 32'h100);
    chk("R7 idle after stop", {31'd0, pwm_out}, 32'd0);
    repeat (5) @(negedge clk);
    rd(3'd3, v2); chk("R7 counter holds", v2, v);

    // R8 write protection while running
    wr(3'd0, 32'd1);
    wr(3'd1, 32'h1234);
    rd(3'd1, v); chk("R8 reload unchanged", v, 32'h100);
    rd(3'd0, v); chk("R8 error set", v, 32'h5);
    wr(3'd4, 32'hF);
    rd(3'd4, v); chk("R8 prescaler unchanged", v, 32'd0);
    wr(3'd0, 32'h5);
    rd(3'd0, v); chk("R8 R9 error cleared", v, 32'h1);
    wr(3'd0, 32'h3);
    rd(3'd0, v); chk("R6 invert ignored while running", v, 32'h1);
    wr(3'd0, 32'd0);
    rd(3'd0, v); chk("R9 stopped ctrl", v, 32'd0);

    // R9 unmapped select
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, v); chk("R9 unmapped read", v, 32'd0);
    rd(3'd2, v); chk("R9 compare unchanged by unmapped write", v, 32'h200);
    chk("R9 output unchanged by unmapped write", {31'd0, pwm_out}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule